// File: doc/BRIEF.md
# Interval Timers with Watchdog

This block holds two interval timers and one watchdog counter. An external timing input is brought into the system clock domain. Each of its rising edges becomes a one-cycle tick. Timer A advances by one on every tick. Timer B advances by one on every tenth tick, through a prescaler. Software starts, halts, loads and reads each timer with 16-bit command codes. When a timer wraps from all ones to zero, the block emits a one-cycle set pulse on the bit of a pending-interrupt vector that belongs to that timer. The pending register itself sits outside this block.

The watchdog counts rising edges of a second, separate clock input. It counts from reset. A kick command clears it. If it runs past all ones, its active-high health output drops and stays low until the next kick. A single active-low freeze input stops all three counters while it is held low.

Top module: `tick_timers`

## Requirements
- R1: After reset both timers are halted with a count of zero, the pending-set vector is zero, `rd_valid` is low and `wd_alive` is high.
- R2: `ext_tick_in` passes through a two-flop synchronizer and a rising-edge detect. A running timer A advances by exactly one for each rising edge of that input.
- R3: A running timer B advances by one for every ten synchronized ticks. Its prescaler advances only while timer B runs.
- R4: When timer A wraps from 16'hFFFF to zero, `pend_set` bit 7 is high for exactly one cycle.
- R5: When timer B wraps from 16'hFFFF to zero, `pend_set` bit 9 is high for exactly one cycle.
- R6: Code 16'h4008 starts timer A and 16'h4009 halts it. Code 16'h400C starts timer B and 16'h400D halts it. A halted timer keeps its count.
- R7: Code 16'h400A loads timer A from `cmd_wdata`, and code 16'h400E loads timer B from `cmd_wdata`. A load takes precedence over a tick in the same cycle. Loading timer B also clears its prescaler.
- R8: Code 16'hC00A reads timer A and code 16'hC00E reads timer B. One cycle after the command, `rd_valid` is high for one cycle and `rd_data` holds the count as it stood when the command was sampled. `rd_data` is zero in every other cycle.
- R9: The watchdog counts rising edges of the synchronized `wd_clk_in`. On wrapping past all ones, `wd_alive` goes low and the count stops. Code 16'h400B clears the count and raises `wd_alive`.
- R10: While `freeze_n` is low, neither timer, the prescaler nor the watchdog advances.
- R11: A command whose code is not one of those listed changes no timer, no watchdog state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_tick_in | input | 1 | Asynchronous timing input for the interval timers |
| wd_clk_in | input | 1 | Asynchronous clock input for the watchdog |
| freeze_n | input | 1 | Active-low freeze of all counting |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 16 | Command code |
| cmd_wdata | input | 16 | Load value for load commands |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 16 | Read result |
| pend_set | output | 16 | One-cycle pending-interrupt set pulses |
| wd_alive | output | 1 | High while the watchdog has not expired |

## Verification
The bench loads timer B in the middle of a prescaler cycle. A design that kept the partial prescale would advance B five ticks early. Timers are loaded just below all ones to force a wrap. The bench checks that the interrupt pulse lasts exactly one cycle and lands on the right bit; a design that kept the pulse or swapped the bit positions is caught by the per-cycle comparison. The watchdog is driven exactly to its limit and then past it. The bench checks that the health output stays low across further edges, so a counter that wrapped back to healthy fails. It also checks that a frozen block counts no edges and that unknown codes leave every count unchanged.

// File: rtl/tick_timers.sv
module tick_timers #(
  parameter int CNT_W       = 16,
  parameter int WD_W        = 16,
  parameter int PRESCALE    = 10,
  parameter int SYNC_STAGES = 2,
  parameter int PEND_W      = 16,
  parameter int IRQ_A_BIT   = 7,
  parameter int IRQ_B_BIT   = 9,
  parameter logic [15:0] CODE_A_START = 16'h4008,
  parameter logic [15:0] CODE_A_HALT  = 16'h4009,
  parameter logic [15:0] CODE_A_LOAD  = 16'h400A,
  parameter logic [15:0] CODE_A_READ  = 16'hC00A,
  parameter logic [15:0] CODE_B_START = 16'h400C,
  parameter logic [15:0] CODE_B_HALT  = 16'h400D,
  parameter logic [15:0] CODE_B_LOAD  = 16'h400E,
  parameter logic [15:0] CODE_B_READ  = 16'hC00E,
  parameter logic [15:0] CODE_GO      = 16'h400B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_tick_in,
  input  logic              wd_clk_in,
  input  logic              freeze_n,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_code,
  input  logic [CNT_W-1:0]  cmd_wdata,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data,
  output logic [PEND_W-1:0] pend_set,
  output logic              wd_alive
);
  localparam int PS_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [SYNC_STAGES:0] ext_sh, wd_sh;
  logic                 ext_tick, wd_tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ext_sh <= '0;
      wd_sh  <= '0;
    end else begin
      ext_sh <= {ext_sh[SYNC_STAGES-1:0], ext_tick_in};
      wd_sh  <= {wd_sh[SYNC_STAGES-1:0], wd_clk_in};
    end

  assign ext_tick = ext_sh[SYNC_STAGES-1] & ~ext_sh[SYNC_STAGES] & freeze_n;
  assign wd_tick  = wd_sh[SYNC_STAGES-1]  & ~wd_sh[SYNC_STAGES]  & freeze_n;

  wire start_a = cmd_valid && cmd_code == CODE_A_START;
  wire halt_a  = cmd_valid && cmd_code == CODE_A_HALT;
  wire load_a  = cmd_valid && cmd_code == CODE_A_LOAD;
  wire read_a  = cmd_valid && cmd_code == CODE_A_READ;
  wire start_b = cmd_valid && cmd_code == CODE_B_START;
  wire halt_b  = cmd_valid && cmd_code == CODE_B_HALT;
  wire load_b  = cmd_valid && cmd_code == CODE_B_LOAD;
  wire read_b  = cmd_valid && cmd_code == CODE_B_READ;
  wire kick    = cmd_valid && cmd_code == CODE_GO;

  logic             run_a, run_b;
  logic [CNT_W-1:0] cnt_a, cnt_b;
  logic [PS_W-1:0]  presc;
  logic [WD_W-1:0]  wd_cnt;

  wire step_a = run_a && ext_tick && !load_a;
  wire step_b = run_b && ext_tick && !load_b && presc == PS_LAST;
  wire ovf_a  = step_a && &cnt_a;
  wire ovf_b  = step_b && &cnt_b;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_a <= 1'b0;
      cnt_a <= '0;
    end else begin
      if (start_a)     run_a <= 1'b1;
      else if (halt_a) run_a <= 1'b0;
      if (load_a)      cnt_a <= cmd_wdata;
      else if (step_a) cnt_a <= cnt_a + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_b <= 1'b0;
      cnt_b <= '0;
      presc <= '0;
    end else begin
      if (start_b)     run_b <= 1'b1;
      else if (halt_b) run_b <= 1'b0;
      if (load_b) begin
        cnt_b <= cmd_wdata;
        presc <= '0;
      end else if (run_b && ext_tick) begin
        presc <= (presc == PS_LAST) ? '0 : presc + 1'b1;
        if (step_b) cnt_b <= cnt_b + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_cnt   <= '0;
      wd_alive <= 1'b1;
    end else if (kick) begin
      wd_cnt   <= '0;
      wd_alive <= 1'b1;
    end else if (wd_alive && wd_tick) begin
      wd_cnt <= wd_cnt + 1'b1;
      if (&wd_cnt) wd_alive <= 1'b0;
    end

  logic [PEND_W-1:0] pend_nxt;
  always_comb begin
    pend_nxt = '0;
    pend_nxt[IRQ_A_BIT] = ovf_a;
    pend_nxt[IRQ_B_BIT] = ovf_b;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_set <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pend_set <= pend_nxt;
      rd_valid <= read_a || read_b;
      rd_data  <= read_a ? cnt_a : (read_b ? cnt_b : '0);
    end
endmodule

// File: rtl/tick_timers_chk.sv
module tick_timers_chk #(
  parameter int PEND_W    = 16,
  parameter int IRQ_A_BIT = 7,
  parameter int IRQ_B_BIT = 9,
  parameter logic [15:0] CODE_A_READ = 16'hC00A,
  parameter logic [15:0] CODE_B_READ = 16'hC00E,
  parameter logic [15:0] CODE_GO     = 16'h400B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze_n,
  input logic              cmd_valid,
  input logic [15:0]       cmd_code,
  input logic              rd_valid,
  input logic [PEND_W-1:0] pend_set,
  input logic              wd_alive
);
  wire rd_cmd = cmd_valid && (cmd_code == CODE_A_READ || cmd_code == CODE_B_READ);
  wire go_cmd = cmd_valid && cmd_code == CODE_GO;

  p_pulse_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set[IRQ_A_BIT] |=> !pend_set[IRQ_A_BIT]);
  p_pulse_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_set[IRQ_B_BIT] |=> !pend_set[IRQ_B_BIT]);
  p_rd_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |=> rd_valid);
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cmd |=> !rd_valid);
  p_go_revives_r9: assert property (@(posedge clk) disable iff (!rst_n)
    go_cmd |=> wd_alive);
  p_expiry_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_alive && !go_cmd) |=> !wd_alive);
  p_frozen_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_n |=> pend_set == '0);
  p_frozen_alive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze_n && !go_cmd) |=> $stable(wd_alive));
endmodule

bind tick_timers tick_timers_chk #(
  .PEND_W(PEND_W), .IRQ_A_BIT(IRQ_A_BIT), .IRQ_B_BIT(IRQ_B_BIT),
  .CODE_A_READ(CODE_A_READ), .CODE_B_READ(CODE_B_READ), .CODE_GO(CODE_GO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_n(freeze_n), .cmd_valid(cmd_valid),
  .cmd_code(cmd_code), .rd_valid(rd_valid), .pend_set(pend_set), .wd_alive(wd_alive)
);

// File: tb/tick_timers_tb_top.sv
`timescale 1ns/1ps
module tick_timers_tb_top;
  localparam int WDMAX = 255;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_tick_in = 1'b0, wd_clk_in = 1'b0, freeze_n = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_code = '0, cmd_wdata = '0;
  logic        rd_valid, wd_alive;
  logic [15:0] rd_data, pend_set;

  always #2 clk = ~clk;

  tick_timers #(.WD_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_tick_in(ext_tick_in), .wd_clk_in(wd_clk_in),
    .freeze_n(freeze_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .pend_set(pend_set), .wd_alive(wd_alive));

  int checks = 0, fails = 0, pulses_a = 0, pulses_b = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  int e1, e2, e3, w1, w2, w3, run_a, run_b, cnt_a, cnt_b, ps, wd, alive;
  int m_pend, m_rdv, m_rdd;
  always @(posedge clk) begin
    if (!rst_n) begin
      e1 = 0; e2 = 0; e3 = 0; w1 = 0; w2 = 0; w3 = 0;
      run_a = 0; run_b = 0; cnt_a = 0; cnt_b = 0; ps = 0; wd = 0; alive = 1;
      m_pend = 0; m_rdv = 0; m_rdd = 0;
    end else begin
      int tk, wtk;
      bit c_sa, c_ha, c_la, c_ra, c_sb, c_hb, c_lb, c_rb, c_go;
      tk  = (e2 && !e3 && freeze_n) ? 1 : 0;
      wtk = (w2 && !w3 && freeze_n) ? 1 : 0;
      e3 = e2; e2 = e1; e1 = int'(ext_tick_in);
      w3 = w2; w2 = w1; w1 = int'(wd_clk_in);
      c_sa = cmd_valid && cmd_code == 16'h4008;
      c_ha = cmd_valid && cmd_code == 16'h4009;
      c_la = cmd_valid && cmd_code == 16'h400A;
      c_ra = cmd_valid && cmd_code == 16'hC00A;
      c_sb = cmd_valid && cmd_code == 16'h400C;
      c_hb = cmd_valid && cmd_code == 16'h400D;
      c_lb = cmd_valid && cmd_code == 16'h400E;
      c_rb = cmd_valid && cmd_code == 16'hC00E;
      c_go = cmd_valid && cmd_code == 16'h400B;
      m_rdv = (c_ra || c_rb) ? 1 : 0;
      m_rdd = c_ra ? cnt_a : (c_rb ? cnt_b : 0);
      m_pend = 0;
      if (c_la) cnt_a = int'(cmd_wdata);
      else if (run_a != 0 && tk != 0) begin
        if (cnt_a == 65535) begin cnt_a = 0; m_pend |= 1 << 7; end
        else cnt_a++;
      end
      if (c_lb) begin cnt_b = int'(cmd_wdata); ps = 0; end
      else if (run_b != 0 && tk != 0) begin
        if (ps == 9) begin
          ps = 0;
          if (cnt_b == 65535) begin cnt_b = 0; m_pend |= 1 << 9; end
          else cnt_b++;
        end else ps++;
      end
      if (c_sa) run_a = 1; else if (c_ha) run_a = 0;
      if (c_sb) run_b = 1; else if (c_hb) run_b = 0;
      if (c_go) begin wd = 0; alive = 1; end
      else if (alive != 0 && wtk != 0) begin
        if (wd == WDMAX) begin wd = 0; alive = 0; end else wd++;
      end
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(int'(pend_set) == m_pend, "R4 R5 pend_set", int'(pend_set), m_pend);
    chk(int'(rd_valid) == m_rdv, "R8 rd_valid", int'(rd_valid), m_rdv);
    chk(int'(rd_data) == m_rdd, "R8 rd_data", int'(rd_data), m_rdd);
    chk(int'(wd_alive) == alive, "R9 wd_alive", int'(wd_alive), alive);
    if (pend_set[7]) pulses_a++;
    if (pend_set[9]) pulses_b++;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic cmd(input logic [15:0] code, input logic [15:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_wdata = data;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; cmd_wdata = '0;
  endtask
  task automatic rd(input logic [15:0] code, output int v);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0;
    v = int'(rd_data);
  endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_tick_in = 1'b1; cyc(1);
      ext_tick_in = 1'b0; cyc(2);
    end
    cyc(2);
  endtask
  task automatic wticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wd_clk_in = 1'b1; cyc(1);
      wd_clk_in = 1'b0; cyc(2);
    end
    cyc(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int v, v2;
    cyc(3);
    chk(pend_set == 0 && !rd_valid && rd_data == 0, "R1 outputs in reset", int'(pend_set), 0);
    chk(wd_alive == 1'b1, "R1 wd_alive in reset", int'(wd_alive), 1);
    @(negedge clk); rst_n = 1'b1;
    rd(16'hC00A, v); chk(v == 0, "R1 timer A zero", v, 0);
    rd(16'hC00E, v); chk(v == 0, "R1 timer B zero", v, 0);
    ticks(3);
    rd(16'hC00A, v); chk(v == 0, "R1 R6 timer A halted after reset", v, 0);

    cmd(16'h4008, 0);
    ticks(5);
    rd(16'hC00A, v); chk(v == 5, "R2 timer A counts ticks", v, 5);
    cmd(16'h4009, 0);
    ticks(3);
    rd(16'hC00A, v); chk(v == 5, "R6 halted timer A holds", v, 5);

    cmd(16'h4008, 0); cmd(16'h400C, 0);
    ticks(9);
    rd(16'hC00E, v); chk(v == 0, "R3 timer B before tenth tick", v, 0);
    ticks(1);
    rd(16'hC00E, v); chk(v == 1, "R3 timer B after ten ticks", v, 1);
    rd(16'hC00A, v); chk(v == 15, "R2 timer A after fifteen", v, 15);

    ticks(5);
    cmd(16'h400E, 16'd100);
    ticks(9);
    rd(16'hC00E, v); chk(v == 100, "R7 load clears prescaler", v, 100);
    ticks(1);
    rd(16'hC00E, v); chk(v == 101, "R7 R3 timer B after load", v, 101);

    cmd(16'h400A, 16'hFFFE);
    ticks(1);
    rd(16'hC00A, v); chk(v == 16'hFFFF, "R7 timer A load", v, 16'hFFFF);
    ticks(1);
    rd(16'hC00A, v); chk(v == 0, "R4 timer A wraps", v, 0);
    chk(pulses_a == 1, "R4 one bit-7 pulse", pulses_a, 1);

    cmd(16'h400E, 16'hFFFF);
    ticks(10);
    rd(16'hC00E, v); chk(v == 0, "R5 timer B wraps", v, 0);
    chk(pulses_b == 1, "R5 one bit-9 pulse", pulses_b, 1);

    rd(16'hC00A, v);
    cmd(16'h4007, 16'h1234); cmd(16'h400F, 16'h5555); cmd(16'hC00B, 0);
    rd(16'hC00A, v2); chk(v2 == v, "R11 unknown codes ignored A", v2, v);
    rd(16'hC00E, v2); chk(v2 == 0, "R11 unknown codes ignored B", v2, 0);

    cmd(16'h400B, 0);
    rd(16'hC00A, v);
    freeze_n = 1'b0;
    ticks(12);
    wticks(300);
    chk(wd_alive == 1'b1, "R10 frozen watchdog alive", int'(wd_alive), 1);
    freeze_n = 1'b1;
    rd(16'hC00A, v2); chk(v2 == v, "R10 frozen timer A", v2, v);
    rd(16'hC00E, v2); chk(v2 == 0, "R10 frozen timer B", v2, 0);

    cmd(16'h400B, 0);
    wticks(WDMAX);
    chk(wd_alive == 1'b1, "R9 watchdog at limit", int'(wd_alive), 1);
    wticks(1);
    chk(wd_alive == 1'b0, "R9 watchdog expired", int'(wd_alive), 0);
    wticks(260);
    chk(wd_alive == 1'b0, "R9 expiry sticky", int'(wd_alive), 0);
    cmd(16'h400B, 0);
    chk(wd_alive == 1'b1, "R9 GO revives", int'(wd_alive), 1);
    wticks(10);
    chk(wd_alive == 1'b1, "R9 counting again", int'(wd_alive), 1);

    cyc(2);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule